// File: doc/BRIEF.md
# Background Multiply Unit with Hi/Lo Result Registers

This block computes the 64-bit product of two 32-bit integers for a simple load-store processor. It takes both operands and a signed/unsigned select in the cycle a start strobe is seen. It then works through the multiplier over a fixed number of iteration cycles. During that time the processor can go on with other work. When the product is complete, its upper half is written into a Hi register and its lower half into a Lo register.

Hi and Lo are always visible on two output buses. A requester that wants to read them raises a read request. If the unit is busy, the request is stalled, and it is granted in the first cycle after the new product has landed. Signed operation works on operand magnitudes and fixes the sign when the result is written, so the most negative operand needs no special case. A parameter sets how many multiplier bits are retired per cycle.

Top module: `mhl_mul_unit`

## Requirements
- R1: With `signed_i` = 0 the operands are treated as unsigned, and {hi_o, lo_o} becomes the zero-extended 64-bit product a*b.
- R2: With `signed_i` = 1 the operands are two's-complement, and {hi_o, lo_o} becomes the exact signed 64-bit product. This includes operands equal to -2^31 (for example (-2^31)*(-2^31) gives hi_o = 0x40000000, lo_o = 0).
- R3: A start seen while idle sets `busy_o` from the next cycle. It stays high for exactly WIDTH/STEP_BITS cycles (32 by default). `done_o` is high for one cycle only: the first cycle in which `busy_o` is low again.
- R4: Operands and the signed select are captured at start. Changes to `op_a_i`, `op_b_i` or `signed_i` while busy do not alter the product.
- R5: A start while busy is ignored. The running operation finishes at its original time with its original product, and no extra result is produced.
- R6: While busy, hi_o and lo_o keep their previous values. Both change together in the cycle `done_o` is high.
- R7: A read request (`rd_req_i` = 1) while busy gives `rd_stall_o` = 1 and `rd_valid_o` = 0. In the first cycle with `busy_o` low it gives `rd_valid_o` = 1, with the new product on hi_o/lo_o.
- R8: After reset `busy_o` = 0, `done_o` = 0, and hi_o = lo_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe issued with the multiply instruction |
| signed_i | input | 1 | 1 = signed multiply, 0 = unsigned multiply |
| op_a_i | input | WIDTH | Multiplicand |
| op_b_i | input | WIDTH | Multiplier |
| busy_o | output | 1 | Product in progress |
| done_o | output | 1 | One-cycle pulse when Hi/Lo have been updated |
| rd_req_i | input | 1 | Requester wants to read Hi/Lo |
| rd_valid_o | output | 1 | Read granted this cycle |
| rd_stall_o | output | 1 | Read held because the unit is busy |
| hi_o | output | WIDTH | Hi register (upper product half) |
| lo_o | output | WIDTH | Lo register (lower product half) |

## Verification
The hardest case to reach from the ports is a second start that arrives mid-operation, carrying different operands and a different signed select, while the first operand buses are also being scrambled. The bench creates it inside the driver task. The task scrambles the inputs and pulses start partway through the busy window. It then checks that the busy window keeps its original length and that the scoreboard receives only the first product. A held read request across the whole window checks the stall, and the grant in the exact cycle the new Hi/Lo appear.

// File: rtl/mhl_pkg.sv
package mhl_pkg;

   typedef enum logic {
      MUL_UNSIGNED = 1'b0,
      MUL_SIGNED   = 1'b1
   } mul_kind_e;

   function automatic int unsigned count_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mhl_operand_prep.sv
module mhl_operand_prep
   import mhl_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  mul_kind_e        kind_i,
   output logic [WIDTH-1:0] mag_a_o,
   output logic [WIDTH-1:0] mag_b_o,
   output logic             neg_o
);

   logic a_neg, b_neg;

   // Sign bits only count for the signed kind; unsigned operands are zero-extended.
   assign a_neg = (kind_i == MUL_SIGNED) && a_i[WIDTH-1];
   assign b_neg = (kind_i == MUL_SIGNED) && b_i[WIDTH-1];

   // Magnitude of -2^(W-1) is 2^(W-1), which still fits in W unsigned bits.
   assign mag_a_o = a_neg ? (~a_i + 1'b1) : a_i;
   assign mag_b_o = b_neg ? (~b_i + 1'b1) : b_i;
   assign neg_o   = a_neg ^ b_neg;

endmodule

// File: rtl/mhl_iter_core.sv
module mhl_iter_core
   import mhl_pkg::*;
#(
   parameter int unsigned WIDTH     = 32,
   parameter int unsigned STEP_BITS = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [WIDTH-1:0]   mcand_i,
   input  logic [WIDTH-1:0]   mplier_i,
   input  logic               neg_i,
   output logic               busy_o,
   output logic               finish_o,
   output logic               done_o,
   output logic [2*WIDTH-1:0] prod_o
);

   localparam int unsigned STEPS = WIDTH / STEP_BITS;
   localparam int unsigned CW    = count_width(STEPS);
   localparam int unsigned SW    = WIDTH + STEP_BITS;
   localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("mhl_iter_core: WIDTH must be at least 2");
      end
      if (STEP_BITS < 1 || STEP_BITS > WIDTH) begin : g_bad_step
         $error("mhl_iter_core: STEP_BITS out of range");
      end
      if ((WIDTH % STEP_BITS) != 0) begin : g_bad_div
         $error("mhl_iter_core: WIDTH must be a multiple of STEP_BITS");
      end
   endgenerate

   logic [2*WIDTH-1:0] acc_q, acc_nxt;
   logic [WIDTH-1:0]   mcand_q;
   logic               neg_q;
   logic               busy_q;
   logic               done_q;
   logic [CW-1:0]      cnt_q;
   logic [SW-1:0]      pp;
   logic [SW-1:0]      sum;

   // Partial product from the lowest STEP_BITS multiplier bits.
   generate
      if (STEP_BITS == 1) begin : g_radix2
         always_comb pp = acc_q[0] ? {1'b0, mcand_q} : '0;
      end else begin : g_radix_hi
         always_comb begin
            pp = '0;
            for (int k = 0; k < int'(STEP_BITS); k++) begin
               if (acc_q[k]) pp = pp + (SW'(mcand_q) << k);
            end
         end
      end
   endgenerate

   assign sum     = SW'(acc_q[2*WIDTH-1:WIDTH]) + pp;
   assign acc_nxt = {sum, acc_q[WIDTH-1:STEP_BITS]};

   assign finish_o = busy_q && (cnt_q == LAST);
   assign prod_o   = neg_q ? (~acc_nxt + 1'b1) : acc_nxt;
   assign busy_o   = busy_q;
   assign done_o   = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         mcand_q <= '0;
         neg_q   <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         cnt_q   <= '0;
      end else begin
         done_q <= finish_o;
         if (!busy_q) begin
            if (load_i) begin
               acc_q   <= {{WIDTH{1'b0}}, mplier_i};
               mcand_q <= mcand_i;
               neg_q   <= neg_i;
               busy_q  <= 1'b1;
               cnt_q   <= '0;
            end
         end else begin
            acc_q <= acc_nxt;
            cnt_q <= cnt_q + 1'b1;
            if (finish_o) busy_q <= 1'b0;
         end
      end
   end

   a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      load_i && !busy_o |=> busy_o && !done_o);

   a_r3_finish_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
      finish_o |=> !busy_o && done_o);

   a_r5_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && load_i && !finish_o |=> busy_o && (cnt_q == CW'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/mhl_hilo_regs.sv
module mhl_hilo_regs #(
   parameter int unsigned WIDTH = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [2*WIDTH-1:0] prod_i,
   input  logic               busy_i,
   input  logic               rd_req_i,
   output logic [WIDTH-1:0]   hi_o,
   output logic [WIDTH-1:0]   lo_o,
   output logic               rd_valid_o,
   output logic               rd_stall_o
);

   logic [WIDTH-1:0] hi_q, lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (wr_i) begin
         hi_q <= prod_i[2*WIDTH-1:WIDTH];
         lo_q <= prod_i[WIDTH-1:0];
      end
   end

   assign hi_o       = hi_q;
   assign lo_o       = lo_q;
   assign rd_stall_o = rd_req_i && busy_i;
   assign rd_valid_o = rd_req_i && !busy_i;

   a_r6_hilo_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i && !wr_i |=> $stable(hi_q) && $stable(lo_q));

endmodule

// File: rtl/mhl_mul_unit.sv
module mhl_mul_unit
   import mhl_pkg::*;
#(
   parameter int unsigned WIDTH     = 32,
   parameter int unsigned STEP_BITS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             signed_i,
   input  logic [WIDTH-1:0] op_a_i,
   input  logic [WIDTH-1:0] op_b_i,
   output logic             busy_o,
   output logic             done_o,
   input  logic             rd_req_i,
   output logic             rd_valid_o,
   output logic             rd_stall_o,
   output logic [WIDTH-1:0] hi_o,
   output logic [WIDTH-1:0] lo_o
);

   logic [WIDTH-1:0]   mag_a, mag_b;
   logic               neg;
   logic               finish;
   logic [2*WIDTH-1:0] prod;
   mul_kind_e          kind;

   assign kind = signed_i ? MUL_SIGNED : MUL_UNSIGNED;

   mhl_operand_prep #(.WIDTH(WIDTH)) u_prep (
      .a_i     (op_a_i),
      .b_i     (op_b_i),
      .kind_i  (kind),
      .mag_a_o (mag_a),
      .mag_b_o (mag_b),
      .neg_o   (neg)
   );

   mhl_iter_core #(.WIDTH(WIDTH), .STEP_BITS(STEP_BITS)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (start_i),
      .mcand_i  (mag_a),
      .mplier_i (mag_b),
      .neg_i    (neg),
      .busy_o   (busy_o),
      .finish_o (finish),
      .done_o   (done_o),
      .prod_o   (prod)
   );

   mhl_hilo_regs #(.WIDTH(WIDTH)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (finish),
      .prod_i     (prod),
      .busy_i     (busy_o),
      .rd_req_i   (rd_req_i),
      .hi_o       (hi_o),
      .lo_o       (lo_o),
      .rd_valid_o (rd_valid_o),
      .rd_stall_o (rd_stall_o)
   );

   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r7_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> !busy_o && !rd_stall_o);

   a_r6_change_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hi_o) || !$stable(lo_o) |-> done_o);

endmodule

// File: tb/mhl_mul_unit_tb.sv
module mhl_mul_unit_tb;

   localparam int W        = 32;
   localparam int CLK_PER  = 10;
   localparam int STEPS    = 32;
   localparam int WATCHDOG = 100000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         signed_i = 1'b0;
   logic [W-1:0] op_a_i = '0;
   logic [W-1:0] op_b_i = '0;
   logic         rd_req_i = 1'b0;
   logic         busy_o, done_o, rd_valid_o, rd_stall_o;
   logic [W-1:0] hi_o, lo_o;

   int checks = 0;
   int errors = 0;
   logic [63:0] exp_q[$];
   logic [63:0] last_prod = '0;
   int cyc = 0;

   always #(CLK_PER/2) clk = ~clk;

   mhl_mul_unit #(.WIDTH(W), .STEP_BITS(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
      .op_a_i(op_a_i), .op_b_i(op_b_i), .busy_o(busy_o), .done_o(done_o),
      .rd_req_i(rd_req_i), .rd_valid_o(rd_valid_o), .rd_stall_o(rd_stall_o),
      .hi_o(hi_o), .lo_o(lo_o)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b, input bit s);
      logic signed [63:0] sa, sb;
      if (s) begin
         sa = {{32{a[31]}}, a};
         sb = {{32{b[31]}}, b};
         return 64'(sa * sb);
      end
      return {32'b0, a} * {32'b0, b};
   endfunction

   // Monitor: pops the scoreboard whenever a result is announced.
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected result", {hi_o, lo_o}, 64'h0);
         end else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            check({hi_o, lo_o} == e, "R1/R2 product", {hi_o, lo_o}, e);
            last_prod = e;
         end
      end
   end

   // Driver: one multiply with optional scrambling, restart and held read.
   task automatic run_mul(input logic [31:0] a, input logic [31:0] b, input bit s,
                          input bit disturb, input bit do_read);
      int busy_cycles;
      logic [63:0] prev;
      prev = last_prod;
      exp_q.push_back(model(a, b, s));
      @(negedge clk);
      op_a_i = a; op_b_i = b; signed_i = s; start_i = 1'b1;
      rd_req_i = do_read;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o === 1'b1, "R3 busy after start", 64'(busy_o), 64'd1);
      busy_cycles = 0;
      while (busy_o === 1'b1 && busy_cycles < STEPS + 8) begin
         busy_cycles++;
         if (do_read) begin
            check(rd_stall_o === 1'b1 && rd_valid_o === 1'b0, "R7 stall while busy",
                  {62'b0, rd_stall_o, rd_valid_o}, 64'h2);
         end
         if (busy_cycles == 5) begin
            check({hi_o, lo_o} == prev, "R6 hold while busy", {hi_o, lo_o}, prev);
         end
         if (disturb && busy_cycles == 3) begin
            op_a_i = ~a; op_b_i = b ^ 32'h5A5A_1234; signed_i = ~s; start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
      end
      start_i = 1'b0;
      check(busy_cycles == STEPS, "R3 busy length", 64'(busy_cycles), 64'(STEPS));
      check(done_o === 1'b1, "R3 done with busy low", 64'(done_o), 64'd1);
      if (do_read) begin
         check(rd_valid_o === 1'b1 && rd_stall_o === 1'b0, "R7 grant after busy",
               {62'b0, rd_stall_o, rd_valid_o}, 64'h1);
         check({hi_o, lo_o} == model(a, b, s), "R7 data at grant", {hi_o, lo_o}, model(a, b, s));
      end
      rd_req_i = 1'b0;
      @(negedge clk);
      check(done_o === 1'b0, "R3 done single pulse", 64'(done_o), 64'd0);
      if (disturb) begin
         check(busy_o === 1'b0 && exp_q.size() == 0, "R5 restart ignored",
               64'(busy_o), 64'd0);
         check({hi_o, lo_o} == model(a, b, s), "R4 captured operands",
               {hi_o, lo_o}, model(a, b, s));
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > WATCHDOG) begin
            check(1'b0, "watchdog", 64'(cyc), 64'(WATCHDOG));
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] lf;
      repeat (3) @(negedge clk);
      check(busy_o === 1'b0 && done_o === 1'b0, "R8 reset flags", {62'b0, busy_o, done_o}, 64'h0);
      check({hi_o, lo_o} == 64'h0, "R8 reset hilo", {hi_o, lo_o}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      run_mul(32'd123, 32'd57, 1'b0, 1'b0, 1'b0);                 // R1
      run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1);    // R1 max, R7
      run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);    // R2 -1*-1
      run_mul(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 1'b1);    // R2 most negative
      run_mul(32'h8000_0000, 32'h0000_0001, 1'b1, 1'b0, 1'b0);    // R2
      run_mul(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 1'b0, 1'b0);    // R2
      run_mul(32'hFFFF_FFF9, 32'd1000, 1'b1, 1'b0, 1'b0);         // R2 mixed sign
      run_mul(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 1'b0);    // R1 unsigned same bits
      run_mul(32'd0, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0);            // zero
      run_mul(32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 1'b1, 1'b1);    // R4, R5, R6, R7
      run_mul(32'hCAFE_F00D, 32'h0BAD_C0DE, 1'b0, 1'b1, 1'b0);    // R4, R5

      lf = 32'hACE1_2345;
      for (int i = 0; i < 16; i++) begin
         logic [31:0] x, y;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         x = lf;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         y = lf ^ 32'h3C3C_0F0F;
         run_mul(x, y, i[0], i[2], i[1]);
      end

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R5 scoreboard drained", 64'(exp_q.size()), 64'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule